// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers single-cycle event pulses from sixteen interrupt sources into a sticky status register. Software enables sources through a mask register and acknowledges events by writing the status register. A status write is an AND: each written 0 clears its bit, and each written 1 leaves its bit as it was. The block drives one pending line to the processor. This line is high whenever any status bit that is set is also enabled in the mask.

Both registers sit behind a simple register bus with an address, a write strobe, write data and read data. Reads are combinational and return the current register value, zero-extended to the bus width. The pending line is registered. It follows the status and mask registers one clock later, so it is refreshed after every write to either register and after every new event. Source index 3 carries the DMA interrupt.

The reset input is asynchronous and active low. It clears the block at once, but its release passes through a two-flop synchronizer, so the block leaves reset two clock edges after the input rises.

Top module: `irq_stat_mask_ctrl`

## Requirements
- R1: While reset is applied, and after it is released, the status register, the mask register and the pending output all read as zero.
- R2: A pulse on `src_set_i[n]` sets status bit n at the next clock edge, and the bit stays set until software clears it. Bit 3 is the DMA source.
- R3: A write to offset 0x70 replaces status with (old status AND `bus_wdata_i[15:0]`). A written 0 clears its bit and a written 1 keeps it.
- R4: A write to offset 0x74 loads `bus_wdata_i[15:0]` into the mask register at the next clock edge.
- R5: `irq_pending_o` equals the OR-reduction of (status AND mask) as held one clock earlier. It therefore changes one edge after the register that causes the change.
- R6: When a set pulse and a status write that clears the same bit happen in the same cycle, the bit ends up set.
- R7: Reads are combinational. Offset 0x70 returns {16'h0, status}, offset 0x74 returns {16'h0, mask}, and every other offset returns zero.
- R8: Writes to offsets other than 0x70 and 0x74 change neither register, and write-data bits 31:16 have no effect.
- R9: When `bus_we_i` is low, the bus changes neither register, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set_i | input | 16 | One-cycle event pulses, one per source |
| bus_addr_i | input | 8 | Register offset |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| irq_pending_o | output | 1 | Registered pending interrupt to the processor |

## Verification
Two functions can act on the same status bit in one cycle: a source raising its event, and software clearing that bit with an acknowledge write. The bench provokes this by driving a set pulse on bit 0 in the same cycle as a status write of all zeros. It judges the result by reading the status back over the bus and expecting bit 0 to still be set. The bench also checks that the pending line moves exactly one edge after such changes.

// File: rtl/ics_pkg.sv
package ics_pkg;
  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_STAT = 2'd1,
    RSEL_MASK = 2'd2
  } rsel_e;

  localparam int unsigned DMA_SRC_IDX = 3;
endpackage

// File: rtl/ics_rst_sync.sv
module ics_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ics_decode.sv
module ics_decode #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h70,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h74
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output logic              stat_we_o,
  output logic              mask_we_o,
  output ics_pkg::rsel_e    rsel_o
);
  logic hit_stat, hit_mask;

  always_comb begin
    hit_stat  = (addr_i == STAT_OFS);
    hit_mask  = (addr_i == MASK_OFS);
    stat_we_o = we_i & hit_stat;
    mask_we_o = we_i & hit_mask;
    if (hit_stat)      rsel_o = ics_pkg::RSEL_STAT;
    else if (hit_mask) rsel_o = ics_pkg::RSEL_MASK;
    else               rsel_o = ics_pkg::RSEL_NONE;
  end
endmodule

// File: rtl/ics_status_reg.sv
module ics_status_reg #(
  parameter int unsigned NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic            ack_we_i,
  input  logic [NSRC-1:0] ack_data_i,
  output logic [NSRC-1:0] stat_o
);
  logic [NSRC-1:0] stat_q;
  logic [NSRC-1:0] stat_d;
  logic [NSRC-1:0] stat_en;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    // Keep the bit unless a write clears it; a new event always wins.
    always_comb begin
      stat_d[i]  = (stat_q[i] & (~ack_we_i | ack_data_i[i])) | set_i[i];
      stat_en[i] = ack_we_i | set_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          stat_q[i] <= 1'b0;
      else if (stat_en[i]) stat_q[i] <= stat_d[i];
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/ics_mask_reg.sv
module ics_mask_reg #(
  parameter int unsigned NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [NSRC-1:0] data_i,
  output logic [NSRC-1:0] mask_o
);
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] mask_d;

  always_comb mask_d = data_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= '0;
    else if (load_i) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/ics_pending.sv
module ics_pending #(
  parameter int unsigned NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] stat_i,
  input  logic [NSRC-1:0] mask_i,
  output logic            pend_o
);
  logic pend_d, pend_q;

  always_comb pend_d = |(stat_i & mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_stat_mask_ctrl.sv
module irq_stat_mask_ctrl #(
  parameter int unsigned NSRC   = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h70,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h74
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_set_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_pending_o
);
  localparam int unsigned PAD_W = DATA_W - NSRC;

  logic            rst_sync_n;
  logic            stat_we, mask_we;
  ics_pkg::rsel_e  rsel;
  logic [NSRC-1:0] stat_q, mask_q;
  logic [NSRC-1:0] wr_low;
  logic            unused_hi;

  assign wr_low    = bus_wdata_i[NSRC-1:0];
  assign unused_hi = ^bus_wdata_i[DATA_W-1:NSRC];

  ics_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ics_decode #(
    .ADDR_W (ADDR_W), .STAT_OFS (STAT_OFS), .MASK_OFS (MASK_OFS)
  ) u_dec (
    .addr_i    (bus_addr_i),
    .we_i      (bus_we_i),
    .stat_we_o (stat_we),
    .mask_we_o (mask_we),
    .rsel_o    (rsel)
  );

  ics_status_reg #(.NSRC (NSRC)) u_stat (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .set_i      (src_set_i),
    .ack_we_i   (stat_we),
    .ack_data_i (wr_low),
    .stat_o     (stat_q)
  );

  ics_mask_reg #(.NSRC (NSRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (mask_we),
    .data_i (wr_low),
    .mask_o (mask_q)
  );

  ics_pending #(.NSRC (NSRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .stat_i (stat_q),
    .mask_i (mask_q),
    .pend_o (irq_pending_o)
  );

  always_comb begin
    unique case (rsel)
      ics_pkg::RSEL_STAT: bus_rdata_o = {{PAD_W{1'b0}}, stat_q};
      ics_pkg::RSEL_MASK: bus_rdata_o = {{PAD_W{1'b0}}, mask_q};
      default:            bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_stat_mask_ctrl_chk.sv
module irq_stat_mask_ctrl_chk #(
  parameter int unsigned NSRC   = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h70,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h74
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [NSRC-1:0]   src_set_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_we_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [NSRC-1:0]   stat_q,
  input logic [NSRC-1:0]   mask_q,
  input logic              irq_pending_o
);
  // R2 / R6: every pulsed source is set one edge later.
  a_r2_set_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|src_set_i) |=> ((stat_q & $past(src_set_i)) == $past(src_set_i)));

  // R3: no bit survives unless old AND written, or newly pulsed.
  a_r3_ack_and: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we_i && bus_addr_i == STAT_OFS) |=>
      ((stat_q & ~(($past(stat_q) & $past(bus_wdata_i[NSRC-1:0])) | $past(src_set_i))) == '0));

  // R4: mask load.
  a_r4_mask_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we_i && bus_addr_i == MASK_OFS) |=> (mask_q == $past(bus_wdata_i[NSRC-1:0])));

  // R8 / R9: mask holds when not addressed for a write.
  a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bus_we_i && bus_addr_i == MASK_OFS) |=> $stable(mask_q));

  // R5: pending follows the registers one edge later.
  a_r5_pending: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (irq_pending_o == (|($past(stat_q) & $past(mask_q)))));
endmodule

bind irq_stat_mask_ctrl irq_stat_mask_ctrl_chk #(
  .NSRC (NSRC), .ADDR_W (ADDR_W), .DATA_W (DATA_W),
  .STAT_OFS (STAT_OFS), .MASK_OFS (MASK_OFS)
) u_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .src_set_i     (src_set_i),
  .bus_addr_i    (bus_addr_i),
  .bus_we_i      (bus_we_i),
  .bus_wdata_i   (bus_wdata_i),
  .stat_q        (stat_q),
  .mask_q        (mask_q),
  .irq_pending_o (irq_pending_o)
);

// File: tb/irq_stat_mask_ctrl_tb.sv
`timescale 1ns/1ps
module irq_stat_mask_ctrl_tb;
  localparam logic [7:0] A_STAT = 8'h70;
  localparam logic [7:0] A_MASK = 8'h74;

  typedef struct packed {
    logic [15:0] set;
    logic        we;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [3:0]  req;
    logic [15:0] exp_stat;
    logic [15:0] exp_mask;
    logic        exp_pend;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{16'h0008, 1'b0, 8'h70, 32'h0000_0000, 4'd2, 16'h0008, 16'h0000, 1'b0}, // R2 DMA bit 3
    '{16'h8001, 1'b0, 8'h70, 32'h0000_0000, 4'd2, 16'h8009, 16'h0000, 1'b0}, // R2 sticky
    '{16'h0000, 1'b1, 8'h74, 32'hFFFF_0008, 4'd4, 16'h8009, 16'h0008, 1'b1}, // R4, R8 upper bits
    '{16'h0000, 1'b1, 8'h70, 32'h0000_FFF7, 4'd3, 16'h8001, 16'h0008, 1'b0}, // R3 clear bit 3
    '{16'h0000, 1'b1, 8'h74, 32'h0000_0001, 4'd4, 16'h8001, 16'h0001, 1'b1}, // R4
    '{16'h0001, 1'b1, 8'h70, 32'h0000_0000, 4'd6, 16'h0001, 16'h0001, 1'b1}, // R6 set wins
    '{16'h0000, 1'b1, 8'h78, 32'h0000_0000, 4'd8, 16'h0001, 16'h0001, 1'b1}, // R8 other offset
    '{16'h0000, 1'b0, 8'h70, 32'h0000_0000, 4'd9, 16'h0001, 16'h0001, 1'b1}, // R9 no strobe
    '{16'h0000, 1'b1, 8'h70, 32'hFFFF_FFFE, 4'd3, 16'h0000, 16'h0001, 1'b0}, // R3
    '{16'h0420, 1'b1, 8'h74, 32'h0000_0400, 4'd5, 16'h0420, 16'h0400, 1'b1}, // R5
    '{16'h0000, 1'b1, 8'h70, 32'h0000_0020, 4'd3, 16'h0020, 16'h0400, 1'b0}, // R3, R5
    '{16'h0000, 1'b1, 8'h74, 32'h0000_FFFF, 4'd5, 16'h0020, 16'hFFFF, 1'b1}  // R5
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] src_set;
  logic [7:0]  addr;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        pend;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  irq_stat_mask_ctrl u_dut (
    .clk (clk), .rst_n (rst_n), .src_set_i (src_set),
    .bus_addr_i (addr), .bus_we_i (we), .bus_wdata_i (wdata),
    .bus_rdata_o (rdata), .irq_pending_o (pend)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    src_set = '0; we = 1'b0; wdata = '0; addr = 8'h00;
  endtask

  task automatic read_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a; we = 1'b0;
    #0.4;
    check(req, rdata, exp);
  endtask

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state while reset is applied
    read_chk("R1", A_STAT, 32'h0);
    read_chk("R1", A_MASK, 32'h0);
    check("R1", {31'b0, pend}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_chk("R1", A_STAT, 32'h0);
    check("R1", {31'b0, pend}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      src_set = VEC[i].set; we = VEC[i].we; addr = VEC[i].addr; wdata = VEC[i].wdata;
      @(negedge clk);
      idle();
      read_chk($sformatf("R%0d vec %0d status", VEC[i].req, i), A_STAT, {16'h0, VEC[i].exp_stat});
      read_chk($sformatf("R%0d vec %0d mask", VEC[i].req, i), A_MASK, {16'h0, VEC[i].exp_mask});
      @(negedge clk);
      check($sformatf("R%0d vec %0d pending", VEC[i].req, i), {31'b0, pend}, {31'b0, VEC[i].exp_pend});
    end

    // R1: asynchronous reset mid-run clears everything at once
    rst_n = 1'b0;
    #0.5;
    read_chk("R1 mid-run", A_STAT, 32'h0);
    read_chk("R1 mid-run", A_MASK, 32'h0);
    check("R1 mid-run", {31'b0, pend}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5: latency of one edge after the status register
    we = 1'b1; addr = A_MASK; wdata = 32'h0000_0002;
    @(negedge clk);
    idle(); src_set = 16'h0002;
    @(negedge clk);
    idle();
    read_chk("R2 latency", A_STAT, 32'h0000_0002);
    check("R5 not yet", {31'b0, pend}, 32'h0);
    // R7: unmapped offsets read zero even with state nonzero
    read_chk("R7 unmapped 0x72", 8'h72, 32'h0);
    read_chk("R7 unmapped 0x00", 8'h00, 32'h0);
    @(negedge clk);
    check("R5 rises", {31'b0, pend}, 32'h1);
    we = 1'b1; addr = A_STAT; wdata = 32'h0;
    @(negedge clk);
    idle();
    read_chk("R3 cleared", A_STAT, 32'h0);
    check("R5 still high", {31'b0, pend}, 32'h1);
    @(negedge clk);
    check("R5 falls", {31'b0, pend}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #20000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule